// File: doc/BRIEF.md
# Write Strobe and Data Launcher for a Double-Data-Rate Memory Bus

This block sits on the controller side of a double-data-rate memory interface and sends write data to the memory. It runs on a clock at twice the memory clock rate. Write data arrives as a stream of word pairs, where each pair is one memory-clock cycle of bus data, together with a byte mask for each word. The block launches data and mask on the rising edge of its clock. It launches the data strobe on the falling edge, so every strobe transition lands in the middle of a data word. The block builds the whole strobe pattern: an output enable, a low preamble of one memory cycle, one transition per word, and a low postamble of half a memory cycle. Output enables are provided for the data and for the strobe, so that pads outside the block can tri-state the bus.

Each byte lane has its own strobe and its own enables. A burst is as many pairs as the source offers back to back. One pair gives 2 words, two pairs give 4, and four pairs give 8. When a new pair is ready at the moment the current pair ends, the strobe keeps toggling with no postamble and no fresh preamble. When another device has been driving the bus, which the plain flag `bus_other` reports, the block waits a fixed number of fast-clock cycles after that flag drops before it accepts a request. This keeps its preamble clear of the other driver's postamble.

The input stream uses valid/ready. A pair transfers on a rising edge where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and the pair data stable until that transfer happens. `s_ready` is high only in these cycles:
- when the block is idle and the bus is free;
- in the second-word cycle of a pair, when the bus is free.

It is low during the preamble and the first word of each pair, and throughout the turnaround window.

Top module: `wrs_top`

## Requirements
- R1: After reset, `dq`, `dm`, `dq_oe`, `dqs` and `dqs_oe` are all zero, and `s_ready` is 1 while `bus_other` is 0.
- R2: A first pair is accepted at rising edge t0. `dqs_oe` then rises at the falling edge inside cycle t0. `dqs` stays 0 for the two fast cycles t0 and t0+1 (the preamble), and `s_ready` is 0 in those two cycles.
- R3: For a run of N accepted pairs, word w (0 <= w < 2N) is on `dq`, and its mask is on `dm`, during cycle t0+2+w, with `dq_oe` at 1. Word 2k is the first word of pair k and word 2k+1 is its second word. A mask bit of 1 marks a lane byte not to be written. When `dq_oe` is 0, `dq` and `dm` are 0.
- R4: `dqs` changes at the falling edge in the middle of each word cycle. It goes to 1 in even-numbered words and to 0 in odd-numbered words, so in the first half of a word cycle it still shows the previous level.
- R5: After the last word, `dqs` stays 0 with `dqs_oe` at 1 for half a memory cycle. `dqs_oe` falls at the falling edge inside cycle t0+2+2N. When `dqs_oe` is 0, `dqs` is 0.
- R6: Pair k (k >= 1) of a back-to-back run is accepted at edge t0+2+2k, because `s_ready` is 1 only in the second-word cycles t0+3+2j. The strobe keeps toggling across pair boundaries with no preamble or postamble.
- R7: `s_ready` is 0 while `bus_other` is 1. It stays 0 until TURN_CYC rising edges have seen `bus_other` at 0, and it is 1 in the cycle after the last of those edges. A request that waits in this window causes no output activity: `dq_oe` and `dqs_oe` stay 0.
- R8: Lane l carries bits [8l+7:8l] of the words and bit l of the masks. Each lane drives its own `dqs[l]` and `dqs_oe[l]`, all lanes with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | A word pair is offered |
| s_ready | output | 1 | A pair is taken at the next rising edge if valid |
| s_word0 | input | LANES*LANE_W | First word of the pair |
| s_word1 | input | LANES*LANE_W | Second word of the pair |
| s_mask0 | input | LANES | Byte mask of the first word, 1 = do not write |
| s_mask1 | input | LANES | Byte mask of the second word |
| bus_other | input | 1 | Another device currently drives the data bus |
| dq | output | LANES*LANE_W | Write data toward the pads |
| dm | output | LANES | Write mask toward the pads |
| dq_oe | output | LANES | Data and mask output enable per lane |
| dqs | output | LANES | Data strobe per lane |
| dqs_oe | output | LANES | Strobe output enable per lane |

## Verification
Each result has a fixed cycle, counted from the rising edge t0 that accepts the first pair:
- the strobe enable rises half a cycle after t0;
- word w sits on the data pins from edge t0+2+w, with the strobe moving half a cycle later;
- the strobe enable drops half a cycle into cycle t0+2+2N;
- `s_ready` goes high in the cycle after the last of TURN_CYC turnaround edges.

The bench drives inputs 1 ns after each rising edge and samples twice per cycle: 2 ns after the rising edge (before the falling edge) and 7 ns after it (after the falling edge). The two samples separate the strobe level before and after its mid-word transition, and they catch the postamble half cycle. Expected values for every cycle of each burst come from these offsets, applied over a sweep of burst lengths, data patterns and turnaround cases.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_W0,
    ST_W1
  } wrs_state_e;

  typedef enum logic [1:0] {
    LD_ZERO,
    LD_IN0,
    LD_P0,
    LD_P1
  } wrs_ld_e;
endpackage

// File: rtl/wrs_turn.sv
module wrs_turn #(
  parameter int TURN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_other,
  output logic bus_free
);
  localparam int CW = $clog2(TURN_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (bus_other)
      cnt <= CW'(TURN_CYC);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign bus_free = !bus_other && (cnt == '0);
endmodule

// File: rtl/wrs_seq.sv
module wrs_seq
  import wrs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     s_valid,
  input  logic     bus_free,
  input  logic     bus_other,
  output logic     s_ready,
  output logic     cap,
  output wrs_ld_e  ld,
  output logic     drv_nxt,
  output logic     stb_lvl,
  output logic     stb_en
);
  wrs_state_e st, nst;
  logic       sub, nsub;
  logic       acc;

  assign s_ready = bus_free && ((st == ST_IDLE) || (st == ST_W1));
  assign acc     = s_valid && s_ready;

  always_comb begin
    nst  = st;
    nsub = sub;
    cap  = 1'b0;
    ld   = LD_ZERO;
    case (st)
      ST_IDLE: if (acc) begin
        nst  = ST_PRE;
        nsub = 1'b0;
        cap  = 1'b1;
      end
      ST_PRE: if (!sub) begin
        nsub = 1'b1;
      end else begin
        nst = ST_W0;
        ld  = LD_P0;
      end
      ST_W0: begin
        nst = ST_W1;
        ld  = LD_P1;
      end
      ST_W1: if (acc) begin
        nst = ST_W0;
        cap = 1'b1;
        ld  = LD_IN0;
      end else begin
        nst = ST_IDLE;
      end
      default: nst = ST_IDLE;
    endcase
  end

  assign drv_nxt = (nst == ST_W0) || (nst == ST_W1);
  assign stb_lvl = (st == ST_W0);
  assign stb_en  = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      sub <= 1'b0;
    end else begin
      st  <= nst;
      sub <= nsub;
    end
  end

  AST_PRE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE && sub) |=> (st == ST_W0)); // R2
  AST_PAIR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_W0) |=> (st == ST_W1)); // R3
  AST_TURN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_other |=> !s_ready); // R7
endmodule

// File: rtl/wrs_lane.sv
module wrs_lane
  import wrs_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  wrs_ld_e           ld,
  input  logic              drv_nxt,
  input  logic              stb_lvl,
  input  logic              stb_en,
  input  logic [LANE_W-1:0] in0,
  input  logic [LANE_W-1:0] in1,
  input  logic              m0,
  input  logic              m1,
  output logic [LANE_W-1:0] dq,
  output logic              dm,
  output logic              dq_oe,
  output logic              dqs,
  output logic              dqs_oe
);
  logic [LANE_W-1:0] p0, p1;
  logic              pm0, pm1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0 <= '0; p1 <= '0; pm0 <= 1'b0; pm1 <= 1'b0;
      dq <= '0; dm <= 1'b0; dq_oe <= 1'b0;
    end else begin
      if (cap) begin
        p0 <= in0; p1 <= in1; pm0 <= m0; pm1 <= m1;
      end
      dq_oe <= drv_nxt;
      case (ld)
        LD_IN0:  begin dq <= in0; dm <= m0;  end
        LD_P0:   begin dq <= p0;  dm <= pm0; end
        LD_P1:   begin dq <= p1;  dm <= pm1; end
        default: begin dq <= '0;  dm <= 1'b0; end
      endcase
    end
  end

  // Strobe is retimed on the opposite edge for a quarter-memory-cycle offset.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqs    <= 1'b0;
      dqs_oe <= 1'b0;
    end else begin
      dqs    <= stb_lvl;
      dqs_oe <= stb_en;
    end
  end

  AST_OE_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe); // R4
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_oe |-> !dqs); // R5
endmodule

// File: rtl/wrs_top.sv
module wrs_top
  import wrs_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int TURN_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [LANES*LANE_W-1:0] s_word0,
  input  logic [LANES*LANE_W-1:0] s_word1,
  input  logic [LANES-1:0]        s_mask0,
  input  logic [LANES-1:0]        s_mask1,
  input  logic                    bus_other,
  output logic [LANES*LANE_W-1:0] dq,
  output logic [LANES-1:0]        dm,
  output logic [LANES-1:0]        dq_oe,
  output logic [LANES-1:0]        dqs,
  output logic [LANES-1:0]        dqs_oe
);
  logic    bus_free, cap, drv_nxt, stb_lvl, stb_en;
  wrs_ld_e ld;

  wrs_turn #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk(clk), .rst_n(rst_n), .bus_other(bus_other), .bus_free(bus_free)
  );

  wrs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .bus_free(bus_free),
    .bus_other(bus_other), .s_ready(s_ready), .cap(cap), .ld(ld),
    .drv_nxt(drv_nxt), .stb_lvl(stb_lvl), .stb_en(stb_en)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wrs_lane #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .cap(cap), .ld(ld), .drv_nxt(drv_nxt),
      .stb_lvl(stb_lvl), .stb_en(stb_en),
      .in0(s_word0[l*LANE_W +: LANE_W]), .in1(s_word1[l*LANE_W +: LANE_W]),
      .m0(s_mask0[l]), .m1(s_mask1[l]),
      .dq(dq[l*LANE_W +: LANE_W]), .dm(dm[l]), .dq_oe(dq_oe[l]),
      .dqs(dqs[l]), .dqs_oe(dqs_oe[l])
    );
  end
endmodule

// File: tb/wrs_top_test.sv
`timescale 1ns/1ps
module wrs_top_test;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int TURN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [LANES*LW-1:0] s_word0 = '0, s_word1 = '0;
  logic [LANES-1:0] s_mask0 = '0, s_mask1 = '0;
  logic bus_other = 1'b0;
  logic [LANES*LW-1:0] dq;
  logic [LANES-1:0] dm, dq_oe, dqs, dqs_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wrs_top #(.LANES(LANES), .LANE_W(LW), .TURN_CYC(TURN)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_word0(s_word0), .s_word1(s_word1), .s_mask0(s_mask0), .s_mask1(s_mask1),
    .bus_other(bus_other), .dq(dq), .dm(dm), .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [LANES*LW-1:0] wfun(int seed, int w);
    logic [LANES*LW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*LW +: LW] = 8'(seed*29 + w*13 + l*71 + 5);
    return v;
  endfunction

  function automatic logic [LANES-1:0] mfun(int seed, int w);
    return 2'((seed*5 + w*3) ^ (w >> 1));
  endfunction

  function automatic logic [LANES-1:0] rep(bit b);
    return {LANES{b}};
  endfunction

  task automatic drive_pair(int seed, int k);
    s_word0 = wfun(seed, 2*k);
    s_word1 = wfun(seed, 2*k+1);
    s_mask0 = mfun(seed, 2*k);
    s_mask1 = mfun(seed, 2*k+1);
  endtask

  // Entered 1 ns after a rising edge; returns at the same offset.
  task automatic run_burst(int np, int seed, output int waits);
    int  k;
    bit  acc;
    int  w;
    waits = 0;
    s_valid = 1'b1;
    drive_pair(seed, 0);
    forever begin
      #6;
      if (s_ready) break;
      waits++;
      @(posedge clk); #1;
    end
    k = 0;
    acc = 1'b1;
    for (int r = 0; r <= 2*np+2; r++) begin
      @(posedge clk); #1;
      if (acc) begin
        k++;
        if (k < np) drive_pair(seed, k);
        else s_valid = 1'b0;
      end
      #1;
      // early sample: before the mid-cycle strobe edge
      chk($sformatf("R2 R5 early dqs_oe r=%0d", r), 32'(dqs_oe), 32'(rep(r >= 1 && r <= 2*np+2)));
      chk($sformatf("R4 early dqs r=%0d", r), 32'(dqs),
          32'(rep((r-3) >= 0 && (r-3) < 2*np && ((r-3) % 2 == 0))));
      #5;
      // late sample: after the mid-cycle strobe edge
      w = r - 2;
      chk($sformatf("R5 late dqs_oe r=%0d", r), 32'(dqs_oe), 32'(rep(r <= 2*np+1)));
      chk($sformatf("R4 R8 late dqs r=%0d", r), 32'(dqs),
          32'(rep(w >= 0 && w < 2*np && (w % 2 == 0))));
      chk($sformatf("R3 dq_oe r=%0d", r), 32'(dq_oe), 32'(rep(w >= 0 && w < 2*np)));
      chk($sformatf("R3 R8 dq r=%0d", r), 32'(dq),
          (w >= 0 && w < 2*np) ? 32'(wfun(seed, w)) : 32'd0);
      chk($sformatf("R3 dm r=%0d", r), 32'(dm),
          (w >= 0 && w < 2*np) ? 32'(mfun(seed, w)) : 32'd0);
      chk($sformatf("R2 R6 s_ready r=%0d", r), 32'(s_ready),
          32'((r == 2*np+2) || (r >= 3 && (r % 2 == 1) && r <= 2*np+1)));
      acc = s_valid && s_ready;
    end
    @(posedge clk); #1;
  endtask

  task automatic turn_case(int hold, int np, int seed);
    int wt;
    bus_other = 1'b1;
    s_valid = 1'b1;
    drive_pair(seed, 0);
    for (int i = 0; i < hold; i++) begin
      #6;
      chk("R7 ready while other drives", 32'(s_ready), 32'd0);
      @(posedge clk); #1;
    end
    bus_other = 1'b0;
    for (int i = 0; i < TURN; i++) begin
      #6;
      chk($sformatf("R7 ready in gap i=%0d", i), 32'(s_ready), 32'd0);
      chk($sformatf("R7 quiet strobe i=%0d", i), 32'(dqs_oe), 32'd0);
      chk($sformatf("R7 quiet data i=%0d", i), 32'(dq_oe), 32'd0);
      @(posedge clk); #1;
    end
    run_burst(np, seed, wt);
    chk("R7 ready right after gap", 32'(wt), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int wt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #6;
    chk("R1 reset dq", 32'(dq), 32'd0);
    chk("R1 reset dm", 32'(dm), 32'd0);
    chk("R1 reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R1 reset dqs", 32'(dqs), 32'd0);
    chk("R1 reset dqs_oe", 32'(dqs_oe), 32'd0);
    chk("R1 reset ready", 32'(s_ready), 32'd1);
    @(posedge clk); #1;

    for (int seed = 0; seed < 9; seed++) begin
      run_burst(1 << (seed % 3), seed, wt);
      chk("R1 idle ready before burst", 32'(wt), 32'd0);
      if (seed % 2 == 1) begin
        @(posedge clk); #1;
      end
    end

    turn_case(1, 1, 20);
    turn_case(3, 2, 21);
    turn_case(2, 4, 22);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule